// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a single down-counter of up to 32 bits with register-style controls. It loads either at once or in the background, counts down by a prescaled clock, and raises an interrupt flag when the count reaches zero. Software writes a control word, an immediate load value, a background load value and an interrupt-clear strobe. It reads back the live count, the stored load value, the control word, and the raw and masked interrupt status.

The counter can run in 16-bit or 32-bit width. It can reload from the stored value (periodic) or wrap to all ones (free-running). It can also stop at zero (one-shot). In 16-bit width only the low half counts, and the upper halves of the count and load registers keep whatever was last written. Reads therefore return the kept upper half joined to the live lower half.

Top module: `dn_timer`

## Requirements
- R1: After reset the control word reads 0x20, with only interrupt enable set. The load value reads 0 and the count reads 0xFFFFFFFF. Both interrupt outputs are low and the counter does not step.
- R2: The control word fields are: bit 0 one-shot, bit 1 32-bit width (0 = 16-bit), bits 3:2 prescale code, bit 5 interrupt enable, bit 6 periodic (0 = free-running) and bit 7 enable. Bit 4 and bits 31:8 always read 0.
- R3: Prescale code 0 steps the count on every cycle, code 1 on every 16th cycle, and codes 2 and 3 on every 256th cycle. A control write restarts the divider, so the first step lands 1, 16 or 256 cycles after the write edge.
- R4: An immediate load write sets the load value and the full 32-bit count on the same edge, and no step happens on that edge. A background load write changes only the load value, and counting goes on during that cycle.
- R5: In periodic mode, a step taken while the active count is zero reloads the count from the load value. In 16-bit width only the low half is reloaded.
- R6: In free-running mode, a step taken at zero wraps the count to 0xFFFF in 16-bit width or 0xFFFFFFFF in 32-bit width. In 16-bit width the upper 16 count bits never change on a step.
- R7: The raw flag sets on the edge where the active count steps from 1 to 0. It stays set until an interrupt-clear write. A step from 1 to 0 and a clear on the same edge leave the flag set.
- R8: The masked status equals the raw flag ANDed with the interrupt-enable bit.
- R9: In one-shot mode the counter halts at zero after the step from 1 to 0. A control write with enable set releases the halt, and the next step reloads or wraps as R5 and R6 describe.
- R10: In periodic mode, an immediate load write whose active value is zero halts the counter. A nonzero immediate load releases the halt.
- R11: The count steps only while enable is set. It never steps on the edge of a control write or an immediate load write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wdata_i | input | 32 | Write data for all register strobes |
| load_we_i | input | 1 | Immediate load write strobe |
| bgload_we_i | input | 1 | Background load write strobe |
| ctrl_we_i | input | 1 | Control word write strobe |
| intclr_we_i | input | 1 | Interrupt clear write strobe |
| count_o | output | 32 | Current count |
| load_o | output | 32 | Stored load value |
| ctrl_o | output | 32 | Control word readback |
| ris_o | output | 1 | Raw interrupt flag |
| mis_o | output | 1 | Masked interrupt flag |

## Verification
The hardest case to reach is a clear strobe landing on the very edge where the count steps from 1 to 0. The stimulus gets there by running the count down with the divider at code 0, so every step falls at a known cycle, and then issuing the clear one cycle before zero. A second hard case is the one-shot halt followed by a restart. The bench shows the count held at zero for several cycles, then checks that the restart wraps it on the next step. The upper-half retention in 16-bit width is covered by loading a value with a distinctive upper half, then checking both a free-running wrap and a periodic reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W     = 8;
  localparam int B_ONESHOT  = 0;
  localparam int B_SIZE32   = 1;
  localparam int B_PRE_LO   = 2;
  localparam int B_INTEN    = 5;
  localparam int B_PERIODIC = 6;
  localparam int B_EN       = 7;
  localparam logic [CTRL_W-1:0] CTRL_VALID = 8'hEF;
  localparam logic [CTRL_W-1:0] CTRL_RST   = 8'h20;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       inten;
    logic [1:0] pre;
    logic       size32;
    logic       oneshot;
  } tmr_cfg_t;

  function automatic tmr_cfg_t decode_cfg(input logic [CTRL_W-1:0] c);
    tmr_cfg_t r;
    r.en       = c[B_EN];
    r.periodic = c[B_PERIODIC];
    r.inten    = c[B_INTEN];
    r.pre      = c[B_PRE_LO+1:B_PRE_LO];
    r.size32   = c[B_SIZE32];
    r.oneshot  = c[B_ONESHOT];
    return r;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PRE_STEP = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  localparam int DIV_W = 2 * PRE_STEP;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  always_comb begin
    unique case (code_i)
      2'd0:    tick_o = 1'b1;
      2'd1:    tick_o = &div_q[PRE_STEP-1:0];
      default: tick_o = &div_q;  // code 3 aliases code 2
    endcase
  end

  // R3: with divide-by-16 two ticks are never adjacent
  a_r3_div16_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == 2'd1 && tick_o && !restart_i) |=> !tick_o);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_cfg_t         cfg_i,
  input  logic             tick_i,
  input  logic             load_we_i,
  input  logic             bgload_we_i,
  input  logic             ctrl_we_i,
  input  logic             wr_en_bit_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] load_o,
  output logic             hit_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [HALF_W-1:0] ONE_H = 1;
  localparam logic [CNT_W-1:0]  ONE_F = 1;

  logic [CNT_W-1:0] cnt_q, load_q, reload_val, dec_val;
  logic             done_q, step, act_zero, act_one, wd_zero, hi_zero;

  assign hi_zero  = (cnt_q[CNT_W-1:HALF_W] == '0) || !cfg_i.size32;
  assign act_zero = (cnt_q[HALF_W-1:0] == '0) && hi_zero;
  assign act_one  = (cnt_q[HALF_W-1:0] == ONE_H) && hi_zero;
  assign wd_zero  = (wdata_i[HALF_W-1:0] == '0) &&
                    ((wdata_i[CNT_W-1:HALF_W] == '0) || !cfg_i.size32);

  assign step = tick_i && cfg_i.en && !done_q && !load_we_i && !ctrl_we_i;

  always_comb begin
    if (cfg_i.periodic)
      reload_val = cfg_i.size32 ? load_q : {cnt_q[CNT_W-1:HALF_W], load_q[HALF_W-1:0]};
    else
      reload_val = cfg_i.size32 ? '1 : {cnt_q[CNT_W-1:HALF_W], {HALF_W{1'b1}}};
    dec_val = cfg_i.size32 ? (cnt_q - ONE_F)
                           : {cnt_q[CNT_W-1:HALF_W], cnt_q[HALF_W-1:0] - ONE_H};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      load_q <= '0;
      done_q <= 1'b0;
    end else if (load_we_i) begin
      load_q <= wdata_i;
      cnt_q  <= wdata_i;
      if (cfg_i.periodic) done_q <= wd_zero;
    end else begin
      if (bgload_we_i) load_q <= wdata_i;
      if (ctrl_we_i) begin
        if (wr_en_bit_i) done_q <= 1'b0;
      end else if (step) begin
        cnt_q <= act_zero ? reload_val : dec_val;
        if (act_one && cfg_i.oneshot) done_q <= 1'b1;
      end
    end
  end

  assign hit_o  = step && act_one;
  assign cnt_o  = cnt_q;
  assign load_o = load_q;

  // R6: narrow width never alters the upper count half on a step
  a_r6_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !cfg_i.size32) |=> $stable(cnt_q[CNT_W-1:HALF_W]));
  // R9: a halted counter holds its value until software intervenes
  a_r9_halt_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !load_we_i && !ctrl_we_i) |=> $stable(cnt_q));
  // R11: disabled counter does not move without a load
  a_r11_no_step_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_i.en && !load_we_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic inten_i,
  output logic ris_o,
  output logic mis_o
);
  logic ris_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ris_q <= 1'b0;
    else if (hit_i)  ris_q <= 1'b1;  // set beats clear
    else if (clr_i)  ris_q <= 1'b0;
  end

  assign ris_o = ris_q;
  assign mis_o = ris_q & inten_i;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> ris_o);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit_i) |=> !ris_o);
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ris_o && !clr_i) |=> ris_o);
endmodule

// File: rtl/dn_timer.sv
module dn_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRE_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             load_we_i,
  input  logic             bgload_we_i,
  input  logic             ctrl_we_i,
  input  logic             intclr_we_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] ctrl_o,
  output logic             ris_o,
  output logic             mis_o
);
  logic [CTRL_W-1:0] ctrl_q;
  tmr_cfg_t          cfg;
  logic              tick, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= CTRL_RST;
    else if (ctrl_we_i) ctrl_q <= wdata_i[CTRL_W-1:0] & CTRL_VALID;
  end

  assign cfg    = decode_cfg(ctrl_q);
  assign ctrl_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};

  tmr_prescale #(.PRE_STEP(PRE_STEP)) u_pre (
    .clk_i, .rst_ni,
    .restart_i (ctrl_we_i),
    .code_i    (cfg.pre),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .cfg_i       (cfg),
    .tick_i      (tick),
    .load_we_i,
    .bgload_we_i,
    .ctrl_we_i,
    .wr_en_bit_i (wdata_i[B_EN]),
    .wdata_i,
    .cnt_o       (count_o),
    .load_o,
    .hit_o       (hit)
  );

  tmr_irq u_irq (
    .clk_i, .rst_ni,
    .hit_i   (hit),
    .clr_i   (intclr_we_i),
    .inten_i (cfg.inten),
    .ris_o,
    .mis_o
  );

  // R2: reserved control bits never become set
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ctrl_o[4] == 1'b0 && ctrl_o[CNT_W-1:CTRL_W] == '0));
  // R8: masked output stays low while interrupts are disabled
  a_r8_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[B_INTEN] |-> !mis_o);
endmodule

// File: tb/sim_dn_timer.sv
module sim_dn_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic        load_we = 0, bg_we = 0, ctrl_we = 0, clr_we = 0;
  logic [31:0] count, load, ctrl;
  logic        ris, mis;

  always #4 clk = ~clk;  // 125 MHz

  dn_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata),
    .load_we_i(load_we), .bgload_we_i(bg_we), .ctrl_we_i(ctrl_we),
    .intclr_we_i(clr_we), .count_o(count), .load_o(load), .ctrl_o(ctrl),
    .ris_o(ris), .mis_o(mis)
  );

  typedef struct {
    string       req;
    logic [31:0] cnt;
    logic [31:0] ld;
    logic [31:0] ctl;
    logic        ris;
    logic        mis;
  } item_t;

  item_t       sb_q[$];
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] exp_load = 32'h0, exp_ctrl = 32'h20;
  bit          finished = 0;

  task automatic expect_st(input string req, input logic [31:0] c,
                           input logic r, input logic m);
    item_t it;
    it.req = req; it.cnt = c; it.ld = exp_load; it.ctl = exp_ctrl;
    it.ris = r; it.mis = m;
    sb_q.push_back(it);
  endtask

  // monitor: compares between edges
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (count !== it.cnt || load !== it.ld || ctrl !== it.ctl ||
            ris !== it.ris || mis !== it.mis) begin
          n_bad++;
          $display("FAIL %s: actual cnt=%h ld=%h ctl=%h ris=%b mis=%b expected cnt=%h ld=%h ctl=%h ris=%b mis=%b",
                   it.req, count, load, ctrl, ris, mis,
                   it.cnt, it.ld, it.ctl, it.ris, it.mis);
        end
      end
    end
  end

  // kind: 0 load, 1 background load, 2 control, 3 clear
  task automatic wr(input int kind, input logic [31:0] d);
    wdata = d;
    case (kind)
      0: begin load_we = 1; exp_load = d; end
      1: begin bg_we = 1; exp_load = d; end
      2: begin ctrl_we = 1; exp_ctrl = d & 32'hEF; end
      default: clr_we = 1;
    endcase
    @(negedge clk);
    load_we = 0; bg_we = 0; ctrl_we = 0; clr_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_st("R1 reset", 32'hFFFFFFFF, 0, 0);
    idle(1);

    wr(0, 32'd5);            expect_st("R4 load sets count", 32'd5, 0, 0);
    idle(3);                 expect_st("R11 disabled hold", 32'd5, 0, 0);
    wr(2, 32'hE2);           expect_st("R11 no step on ctrl write", 32'd5, 0, 0);
    idle(1);                 expect_st("R3 code0 first step", 32'd4, 0, 0);
    idle(3);                 expect_st("R7 not yet", 32'd1, 0, 0);
    idle(1);                 expect_st("R7 flag at zero", 32'd0, 1, 1);
    idle(1);                 expect_st("R5 periodic reload", 32'd5, 1, 1);

    wr(1, 32'd3);            expect_st("R4 bg load keeps counting", 32'd4, 1, 1);
    idle(4);                 expect_st("R5 reach zero", 32'd0, 1, 1);
    idle(1);                 expect_st("R5 reload from bg value", 32'd3, 1, 1);

    wr(3, 32'd0);            expect_st("R7 clear", 32'd2, 0, 0);
    idle(1);                 expect_st("R7 pre-collision", 32'd1, 0, 0);
    wr(3, 32'd0);            expect_st("R7 set beats clear", 32'd0, 1, 1);
    wr(2, 32'hC2);           expect_st("R8 masked off", 32'd0, 1, 0);
    wr(3, 32'd0);            expect_st("R5 reload after ctrl", 32'd3, 0, 0);

    wr(0, 32'h12340002);     expect_st("R4 full count load", 32'h12340002, 0, 0);
    wr(2, 32'hA0);           expect_st("R2 ctrl readback", 32'h12340002, 0, 0);
    idle(1);                 expect_st("R6 16-bit step", 32'h12340001, 0, 0);
    idle(1);                 expect_st("R7 16-bit zero", 32'h12340000, 1, 1);
    idle(1);                 expect_st("R6 free wrap upper kept", 32'h1234FFFF, 1, 1);

    wr(3, 32'd0);            expect_st("R7 clear again", 32'h1234FFFE, 0, 0);
    wr(0, 32'd3);            expect_st("R4 load in free mode", 32'd3, 0, 0);
    wr(2, 32'hA3);           expect_st("R9 one-shot armed", 32'd3, 0, 0);
    idle(3);                 expect_st("R9 one-shot zero", 32'd0, 1, 1);
    idle(5);                 expect_st("R9 halted", 32'd0, 1, 1);
    wr(2, 32'hA3);           expect_st("R9 restart write", 32'd0, 1, 1);
    idle(1);                 expect_st("R9 restart wraps", 32'hFFFFFFFF, 1, 1);
    idle(1);                 expect_st("R9 continues", 32'hFFFFFFFE, 1, 1);

    wr(2, 32'hE2);           expect_st("R11 ctrl edge", 32'hFFFFFFFE, 1, 1);
    wr(0, 32'd0);            expect_st("R10 zero load", 32'd0, 1, 1);
    idle(3);                 expect_st("R10 stopped", 32'd0, 1, 1);
    wr(0, 32'd7);            expect_st("R10 nonzero load", 32'd7, 1, 1);
    idle(2);                 expect_st("R10 running", 32'd5, 1, 1);

    wr(0, 32'd100);          expect_st("R4 load 100", 32'd100, 1, 1);
    wr(2, 32'hE6);           expect_st("R3 code1 write", 32'd100, 1, 1);
    idle(15);                expect_st("R3 code1 wait", 32'd100, 1, 1);
    idle(1);                 expect_st("R3 code1 step", 32'd99, 1, 1);
    idle(15);                expect_st("R3 code1 gap", 32'd99, 1, 1);
    idle(1);                 expect_st("R3 code1 second", 32'd98, 1, 1);
    wr(2, 32'hEE);           expect_st("R3 code3 write", 32'd98, 1, 1);
    idle(255);               expect_st("R3 code3 wait", 32'd98, 1, 1);
    idle(1);                 expect_st("R3 code3 step", 32'd97, 1, 1);

    wr(2, 32'hFFFFFF1F);     expect_st("R2 reserved bits zero", 32'd97, 1, 0);
    idle(20);                expect_st("R11 enable off", 32'd97, 1, 0);

    wr(0, 32'hABCD0003);     expect_st("R4 load upper", 32'hABCD0003, 1, 0);
    wr(2, 32'hE0);           expect_st("R2 16-bit periodic", 32'hABCD0003, 1, 1);
    wr(1, 32'h00770004);     expect_st("R4 bg in 16-bit", 32'hABCD0002, 1, 1);
    idle(2);                 expect_st("R5 16-bit zero", 32'hABCD0000, 1, 1);
    idle(1);                 expect_st("R5 low-half reload", 32'hABCD0004, 1, 1);

    idle(2);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule